// File: doc/BRIEF.md
# Lane-Reordering Transmit/Receive FIFO Pair

This block holds two 32-entry queues of 32-bit words between a register bus and a serial shifter. Bus writes to the data address fill the transmit queue, and the shifter drains it through a pop port. The shifter fills the receive queue through a push port, and bus reads from the data address drain it. On the way into the transmit queue, and again on the way out of the receive queue, each word can be reordered by one of four byte-lane modes. The mode is chosen separately for each direction.

A control register at the second bus address holds several settings. It sets a programmed level for each queue; the level is the wanted trigger threshold minus one. It also holds the two lane modes, one DMA request enable per direction, and a test-mode bit. Each queue drives a level-sensitive interrupt. It also drives a DMA request, which the enable for that direction gates. The interrupt and request tell the surrounding system when the transmit queue needs refilling or the receive queue needs draining. In test mode the bus reaches the queues directly: data writes go into the receive queue and data reads take words from the transmit queue. The shifter ports are ignored while test mode is on.

Each queue reports its fill count, full and empty flags. Each also has two sticky error flags: one for pushes it drops and one for pops it drops.

Top module: `lane_swap_fifo`

## Requirements
- R1: After reset both queues are empty with count 0, the control register reads 0, and all four sticky error flags are 0.
- R2: A bus write with busAddr=1 loads the control register, and the new setting applies from the next cycle. Its fields are: txSwap bits [1:0], rxSwap bits [3:2], txDmaEn bit 4, rxDmaEn bit 5, testMode bit 6, txLevel bits [12:8] and rxLevel bits [20:16]. All other bits read back as 0 at busAddr=1.
- R3: Normal data writes (busAddr=0) store the word reordered by txSwap. Mode 0 leaves it unchanged. Mode 1 gives {w[15:0],w[31:16]}. Mode 2 gives {w[7:0],w[15:8],w[23:16],w[31:24]}. Mode 3 gives {w[23:16],w[31:24],w[7:0],w[15:8]}.
- R4: Normal data reads return the receive head reordered by rxSwap, using the same four modes, and pop it at the clock edge.
- R5: Each queue is first-in first-out and holds 32 words. The fill count, full (count 32) and empty (count 0) flags update one cycle after each accepted push or pop.
- R6: txIrq is 1 while the transmit count is at most txLevel+1. txDmaReq equals txIrq when txDmaEn is 1.
- R7: rxIrq is 1 while the receive count is at least rxLevel+1. rxDmaReq equals rxIrq when rxDmaEn is 1.
- R8: While its enable bit is 0, a DMA request output stays 0 whatever the fill level.
- R9: A push into a full queue is dropped, leaving count and contents unchanged, and sets that queue's sticky overrun flag until reset.
- R10: A pop from an empty queue is dropped and sets that queue's sticky underrun flag. A data read while the source queue is empty returns 0.
- R11: With testMode=1, data writes push the unreordered word into the receive queue and data reads pop the transmit head unreordered. The shifter's rxPush and txPop inputs have no effect in this mode.
- R12: A push and a pop on the same queue in one cycle are both accepted when it is neither full nor empty, and the count stays the same.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| busSel | input | 1 | Bus access strobe, one cycle per access |
| busWr | input | 1 | 1 = write, 0 = read |
| busAddr | input | 1 | 0 = data, 1 = control register |
| busWdata | input | 32 | Bus write data |
| busRdata | output | 32 | Bus read data, valid in the access cycle |
| txPop | input | 1 | Shifter takes the transmit head |
| txPopData | output | 32 | Current transmit head word |
| rxPush | input | 1 | Shifter delivers a received word |
| rxPushData | input | 32 | Received word |
| txCount | output | 6 | Transmit fill count |
| rxCount | output | 6 | Receive fill count |
| txFull | output | 1 | Transmit queue full |
| txEmpty | output | 1 | Transmit queue empty |
| rxFull | output | 1 | Receive queue full |
| rxEmpty | output | 1 | Receive queue empty |
| txOverrun | output | 1 | Sticky: transmit push dropped |
| txUnderrun | output | 1 | Sticky: transmit pop dropped |
| rxOverrun | output | 1 | Sticky: receive push dropped |
| rxUnderrun | output | 1 | Sticky: receive pop dropped |
| txIrq | output | 1 | Transmit level interrupt |
| rxIrq | output | 1 | Receive level interrupt |
| txDmaReq | output | 1 | Gated transmit DMA request |
| rxDmaReq | output | 1 | Gated receive DMA request |

## Verification
Read data and txPopData are combinational from the stored head, so the bench samples them in the access cycle, shortly after it drives the inputs and before the edge that pops. Counts, full/empty flags, sticky flags, interrupts and DMA requests come from registers. They change at the edge that accepts the push, pop or control write, so the bench samples them at the falling edge that follows. A new control setting is written one full cycle before any data access that depends on it.

// File: rtl/lane_swap_pkg.sv
package lane_swap_pkg;

  localparam int WORD_W = 32;

  typedef struct packed {
    logic [4:0] rxLevel;
    logic [4:0] txLevel;
    logic       testMode;
    logic       rxDmaEn;
    logic       txDmaEn;
    logic [1:0] rxSwap;
    logic [1:0] txSwap;
  } ctrlReg_t;

  // strobes from control to datapath
  typedef struct packed {
    logic       txPush;
    logic       txPop;
    logic       rxPush;
    logic       rxPop;
    logic       rxFromBus;
    logic       readTx;
    logic [1:0] txSwap;
    logic [1:0] rxSwap;
  } fifoStrobe_t;

  function automatic logic [WORD_W-1:0] laneSwap(input logic [WORD_W-1:0] w,
                                                 input logic [1:0] mode);
    case (mode)
      2'd1:    return {w[15:0], w[31:16]};
      2'd2:    return {w[7:0], w[15:8], w[23:16], w[31:24]};
      2'd3:    return {w[23:16], w[31:24], w[7:0], w[15:8]};
      default: return w;
    endcase
  endfunction

  function automatic logic [31:0] packCtrl(input ctrlReg_t c);
    logic [31:0] v;
    v = '0;
    v[1:0]   = c.txSwap;
    v[3:2]   = c.rxSwap;
    v[4]     = c.txDmaEn;
    v[5]     = c.rxDmaEn;
    v[6]     = c.testMode;
    v[12:8]  = c.txLevel;
    v[20:16] = c.rxLevel;
    return v;
  endfunction

  function automatic ctrlReg_t unpackCtrl(input logic [31:0] v);
    ctrlReg_t c;
    c.txSwap   = v[1:0];
    c.rxSwap   = v[3:2];
    c.txDmaEn  = v[4];
    c.rxDmaEn  = v[5];
    c.testMode = v[6];
    c.txLevel  = v[12:8];
    c.rxLevel  = v[20:16];
    return c;
  endfunction

endpackage

// File: rtl/fifo_ring.sv
module fifo_ring #(
  parameter int DATA_W = 32,
  parameter int DEPTH  = 32,
  localparam int PTR_W = $clog2(DEPTH),
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              push,
  input  logic              pop,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] head,
  output logic [CNT_W-1:0]  count
);

  logic [DATA_W-1:0] mem [DEPTH];
  logic [PTR_W-1:0]  wrPtr;
  logic [PTR_W-1:0]  rdPtr;

  always_ff @(posedge clk) begin
    if (push) mem[wrPtr] <= wdata;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      wrPtr <= '0;
      rdPtr <= '0;
      count <= '0;
    end else begin
      if (push) wrPtr <= (wrPtr == PTR_W'(DEPTH - 1)) ? '0 : wrPtr + 1'b1;
      if (pop)  rdPtr <= (rdPtr == PTR_W'(DEPTH - 1)) ? '0 : rdPtr + 1'b1;
      case ({push, pop})
        2'b10:   count <= count + 1'b1;
        2'b01:   count <= count - 1'b1;
        default: count <= count;
      endcase
    end
  end

  assign head = mem[rdPtr];

  // R9: control must never hand a push to a full ring
  p_no_push_full_r9: assert property (@(posedge clk) disable iff (!rstN)
    push |-> (count < CNT_W'(DEPTH)));

  // R10: control must never hand a pop to an empty ring
  p_no_pop_empty_r10: assert property (@(posedge clk) disable iff (!rstN)
    pop |-> (count != '0));

  // R12: count follows accepted strobes
  p_count_track_r12: assert property (@(posedge clk) disable iff (!rstN)
    (push && pop) |=> (count == $past(count)));

endmodule

// File: rtl/fifo_dp.sv
module fifo_dp
  import lane_swap_pkg::*;
#(
  parameter int DEPTH  = 32,
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rstN,
  input  fifoStrobe_t       stb,
  input  logic [WORD_W-1:0] busWdata,
  input  logic [WORD_W-1:0] rxPushData,
  output logic [WORD_W-1:0] busData,
  output logic [WORD_W-1:0] txHead,
  output logic [CNT_W-1:0]  txCount,
  output logic [CNT_W-1:0]  rxCount
);

  logic [WORD_W-1:0] txWdata;
  logic [WORD_W-1:0] rxWdata;
  logic [WORD_W-1:0] rxHead;

  assign txWdata = laneSwap(busWdata, stb.txSwap);
  assign rxWdata = stb.rxFromBus ? busWdata : rxPushData;

  fifo_ring #(.DATA_W(WORD_W), .DEPTH(DEPTH)) i_txRing (
    .clk(clk), .rstN(rstN),
    .push(stb.txPush), .pop(stb.txPop),
    .wdata(txWdata), .head(txHead), .count(txCount)
  );

  fifo_ring #(.DATA_W(WORD_W), .DEPTH(DEPTH)) i_rxRing (
    .clk(clk), .rstN(rstN),
    .push(stb.rxPush), .pop(stb.rxPop),
    .wdata(rxWdata), .head(rxHead), .count(rxCount)
  );

  assign busData = stb.readTx ? txHead : laneSwap(rxHead, stb.rxSwap);

endmodule

// File: rtl/fifo_ctl.sv
module fifo_ctl
  import lane_swap_pkg::*;
#(
  parameter int DEPTH  = 32,
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              busSel,
  input  logic              busWr,
  input  logic              busAddr,
  input  logic [WORD_W-1:0] busWdata,
  input  logic [WORD_W-1:0] busData,
  output logic [WORD_W-1:0] busRdata,
  input  logic              txPopIn,
  input  logic              rxPushIn,
  input  logic [CNT_W-1:0]  txCount,
  input  logic [CNT_W-1:0]  rxCount,
  output fifoStrobe_t       stb,
  output logic              txFull,
  output logic              txEmpty,
  output logic              rxFull,
  output logic              rxEmpty,
  output logic              txOverrun,
  output logic              txUnderrun,
  output logic              rxOverrun,
  output logic              rxUnderrun,
  output logic              txIrq,
  output logic              rxIrq,
  output logic              txDmaReq,
  output logic              rxDmaReq
);

  ctrlReg_t ctrl;
  logic dataWr, dataRd, ctrlWr;
  logic txPushReq, txPopReq, rxPushReq, rxPopReq;
  logic srcEmpty;
  logic [CNT_W-1:0] txThresh, rxThresh;

  assign dataWr = busSel &  busWr & ~busAddr;
  assign dataRd = busSel & ~busWr & ~busAddr;
  assign ctrlWr = busSel &  busWr &  busAddr;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) ctrl <= '0;
    else if (ctrlWr) ctrl <= unpackCtrl(busWdata);
  end

  assign txFull  = (txCount == CNT_W'(DEPTH));
  assign rxFull  = (rxCount == CNT_W'(DEPTH));
  assign txEmpty = (txCount == '0);
  assign rxEmpty = (rxCount == '0);

  // request routing: test mode turns the bus toward the opposite queues
  always_comb begin
    if (ctrl.testMode) begin
      txPushReq = 1'b0;
      rxPushReq = dataWr;
      txPopReq  = dataRd;
      rxPopReq  = 1'b0;
    end else begin
      txPushReq = dataWr;
      rxPushReq = rxPushIn;
      txPopReq  = txPopIn;
      rxPopReq  = dataRd;
    end
  end

  always_comb begin
    stb.txPush    = txPushReq & ~txFull;
    stb.rxPush    = rxPushReq & ~rxFull;
    stb.txPop     = txPopReq  & ~txEmpty;
    stb.rxPop     = rxPopReq  & ~rxEmpty;
    stb.rxFromBus = ctrl.testMode;
    stb.readTx    = ctrl.testMode;
    stb.txSwap    = ctrl.txSwap;
    stb.rxSwap    = ctrl.rxSwap;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      txOverrun  <= 1'b0;
      txUnderrun <= 1'b0;
      rxOverrun  <= 1'b0;
      rxUnderrun <= 1'b0;
    end else begin
      if (txPushReq && txFull)  txOverrun  <= 1'b1;
      if (rxPushReq && rxFull)  rxOverrun  <= 1'b1;
      if (txPopReq  && txEmpty) txUnderrun <= 1'b1;
      if (rxPopReq  && rxEmpty) rxUnderrun <= 1'b1;
    end
  end

  assign srcEmpty = ctrl.testMode ? txEmpty : rxEmpty;

  always_comb begin
    if (busAddr)       busRdata = packCtrl(ctrl);
    else if (srcEmpty) busRdata = '0;
    else               busRdata = busData;
  end

  assign txThresh = CNT_W'(ctrl.txLevel) + 1'b1;
  assign rxThresh = CNT_W'(ctrl.rxLevel) + 1'b1;
  assign txIrq    = (txCount <= txThresh);
  assign rxIrq    = (rxCount >= rxThresh);
  assign txDmaReq = txIrq & ctrl.txDmaEn;
  assign rxDmaReq = rxIrq & ctrl.rxDmaEn;

  // R9: rejected push into a full queue leaves a sticky mark
  p_overrun_set_r9: assert property (@(posedge clk) disable iff (!rstN)
    (txPushReq && txFull) |=> txOverrun);

  // R9: sticky flag holds until reset
  p_overrun_hold_r9: assert property (@(posedge clk) disable iff (!rstN)
    rxOverrun |=> rxOverrun);

  // R10: rejected pop from an empty queue leaves a sticky mark
  p_underrun_set_r10: assert property (@(posedge clk) disable iff (!rstN)
    (rxPopReq && rxEmpty) |=> rxUnderrun);

  // R11: in test mode the shifter cannot move the receive count up
  p_test_shield_r11: assert property (@(posedge clk) disable iff (!rstN)
    (ctrl.testMode && !dataWr) |=> (rxCount <= $past(rxCount)));

endmodule

// File: rtl/lane_swap_fifo.sv
module lane_swap_fifo
  import lane_swap_pkg::*;
#(
  parameter int DEPTH  = 32,
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              busSel,
  input  logic              busWr,
  input  logic              busAddr,
  input  logic [31:0]       busWdata,
  output logic [31:0]       busRdata,
  input  logic              txPop,
  output logic [31:0]       txPopData,
  input  logic              rxPush,
  input  logic [31:0]       rxPushData,
  output logic [CNT_W-1:0]  txCount,
  output logic [CNT_W-1:0]  rxCount,
  output logic              txFull,
  output logic              txEmpty,
  output logic              rxFull,
  output logic              rxEmpty,
  output logic              txOverrun,
  output logic              txUnderrun,
  output logic              rxOverrun,
  output logic              rxUnderrun,
  output logic              txIrq,
  output logic              rxIrq,
  output logic              txDmaReq,
  output logic              rxDmaReq
);

  fifoStrobe_t       stb;
  logic [WORD_W-1:0] busData;

  fifo_ctl #(.DEPTH(DEPTH)) i_ctl (
    .clk(clk), .rstN(rstN),
    .busSel(busSel), .busWr(busWr), .busAddr(busAddr),
    .busWdata(busWdata), .busData(busData), .busRdata(busRdata),
    .txPopIn(txPop), .rxPushIn(rxPush),
    .txCount(txCount), .rxCount(rxCount), .stb(stb),
    .txFull(txFull), .txEmpty(txEmpty), .rxFull(rxFull), .rxEmpty(rxEmpty),
    .txOverrun(txOverrun), .txUnderrun(txUnderrun),
    .rxOverrun(rxOverrun), .rxUnderrun(rxUnderrun),
    .txIrq(txIrq), .rxIrq(rxIrq), .txDmaReq(txDmaReq), .rxDmaReq(rxDmaReq)
  );

  fifo_dp #(.DEPTH(DEPTH)) i_dp (
    .clk(clk), .rstN(rstN), .stb(stb),
    .busWdata(busWdata), .rxPushData(rxPushData),
    .busData(busData), .txHead(txPopData),
    .txCount(txCount), .rxCount(rxCount)
  );

endmodule

// File: tb/test_lane_swap_fifo.sv
module test_lane_swap_fifo;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        busSel = 1'b0, busWr = 1'b0, busAddr = 1'b0;
  logic [31:0] busWdata = '0;
  logic [31:0] busRdata;
  logic        txPop = 1'b0;
  logic [31:0] txPopData;
  logic        rxPush = 1'b0;
  logic [31:0] rxPushData = '0;
  logic [5:0]  txCount, rxCount;
  logic txFull, txEmpty, rxFull, rxEmpty;
  logic txOverrun, txUnderrun, rxOverrun, rxUnderrun;
  logic txIrq, rxIrq, txDmaReq, rxDmaReq;

  int checks = 0;
  int fails  = 0;
  bit finished = 0;

  always #2.5 clk = ~clk;

  lane_swap_fifo i_lane_swap_fifo (.*);

  // independent model of the four lane modes, byte by byte
  function automatic logic [31:0] expSwap(input logic [31:0] w, input int mode);
    logic [7:0] b0, b1, b2, b3;
    b0 = w[7:0]; b1 = w[15:8]; b2 = w[23:16]; b3 = w[31:24];
    case (mode)
      1:       return {b1, b0, b3, b2};
      2:       return {b0, b1, b2, b3};
      3:       return {b2, b3, b0, b1};
      default: return w;
    endcase
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic doReset();
    @(negedge clk);
    rstN = 1'b0;
    tick();
    rstN = 1'b1;
    tick();
  endtask

  task automatic busWrite(input logic addr, input logic [31:0] d);
    busSel = 1'b1; busWr = 1'b1; busAddr = addr; busWdata = d;
    tick();
    busSel = 1'b0; busWr = 1'b0;
  endtask

  task automatic busRead(input logic addr, output logic [31:0] d);
    busSel = 1'b1; busWr = 1'b0; busAddr = addr;
    #1 d = busRdata;
    tick();
    busSel = 1'b0;
  endtask

  task automatic shiftPop(output logic [31:0] d);
    txPop = 1'b1;
    #1 d = txPopData;
    tick();
    txPop = 1'b0;
  endtask

  task automatic shiftPush(input logic [31:0] d);
    rxPush = 1'b1; rxPushData = d;
    tick();
    rxPush = 1'b0;
  endtask

  function automatic logic [31:0] ctrlWord(input int txS, input int rxS, input bit txE,
                                          input bit rxE, input bit tm, input int txL, input int rxL);
    return 32'(txS & 3) | (32'(rxS & 3) << 2) | (32'(txE) << 4) | (32'(rxE) << 5)
         | (32'(tm) << 6) | (32'(txL & 31) << 8) | (32'(rxL & 31) << 16);
  endfunction

  task automatic testReset();
    logic [31:0] d;
    doReset();
    chk("R1 txCount", 32'(txCount), 0);
    chk("R1 rxCount", 32'(rxCount), 0);
    chk("R1 empties", {30'd0, txEmpty, rxEmpty}, 3);
    chk("R1 sticky", {28'd0, txOverrun, txUnderrun, rxOverrun, rxUnderrun}, 0);
    chk("R1 irq/dma", {28'd0, txIrq, rxIrq, txDmaReq, rxDmaReq}, 32'b1000);
    busRead(1'b1, d);
    chk("R1 ctrl", d, 0);
  endtask

  task automatic testCtrlReg();
    logic [31:0] d;
    doReset();
    busWrite(1'b1, 32'hFFFF_FFFF);
    busRead(1'b1, d);
    chk("R2 readback mask", d, 32'h001F_1F7F);
    busWrite(1'b1, ctrlWord(2, 1, 0, 1, 0, 7, 9));
    busRead(1'b1, d);
    chk("R2 readback", d, ctrlWord(2, 1, 0, 1, 0, 7, 9));
  endtask

  task automatic testTxSwap();
    logic [31:0] d;
    doReset();
    for (int m = 0; m < 4; m++) begin
      busWrite(1'b1, ctrlWord(m, 0, 0, 0, 0, 0, 0));
      busWrite(1'b0, 32'h1122_3344);
      shiftPop(d);
      chk($sformatf("R3 tx mode %0d", m), d, expSwap(32'h1122_3344, m));
    end
  endtask

  task automatic testRxSwap();
    logic [31:0] d;
    doReset();
    for (int m = 0; m < 4; m++) begin
      busWrite(1'b1, ctrlWord(0, m, 0, 0, 0, 0, 0));
      shiftPush(32'hA1B2_C3D4);
      busRead(1'b0, d);
      chk($sformatf("R4 rx mode %0d", m), d, expSwap(32'hA1B2_C3D4, m));
      chk("R4 popped", 32'(rxCount), 0);
    end
  endtask

  task automatic testOrderAndFull();
    logic [31:0] d;
    doReset();
    for (int i = 0; i < 32; i++) busWrite(1'b0, 32'h100 + 32'(i));
    chk("R5 tx count full", 32'(txCount), 32);
    chk("R5 tx full flag", {31'd0, txFull}, 1);
    busWrite(1'b0, 32'hDEAD_BEEF);
    chk("R9 tx count kept", 32'(txCount), 32);
    chk("R9 tx overrun", {31'd0, txOverrun}, 1);
    for (int i = 0; i < 32; i++) begin
      shiftPop(d);
      if (i == 0 || i == 31) chk("R5 tx order", d, 32'h100 + 32'(i));
    end
    chk("R5 tx empty", {31'd0, txEmpty}, 1);
    chk("R10 no tx underrun yet", {31'd0, txUnderrun}, 0);
    shiftPop(d);
    chk("R10 tx underrun", {31'd0, txUnderrun}, 1);
    chk("R9 overrun still sticky", {31'd0, txOverrun}, 1);
  endtask

  task automatic testRxLimits();
    logic [31:0] d;
    doReset();
    for (int i = 0; i < 33; i++) shiftPush(32'h200 + 32'(i));
    chk("R9 rx count", 32'(rxCount), 32);
    chk("R9 rx overrun", {31'd0, rxOverrun}, 1);
    for (int i = 0; i < 32; i++) begin
      busRead(1'b0, d);
      if (i == 31) chk("R5 rx last kept", d, 32'h21F);
    end
    busRead(1'b0, d);
    chk("R10 empty read zero", d, 0);
    chk("R10 rx underrun", {31'd0, rxUnderrun}, 1);
    chk("R10 rx count", 32'(rxCount), 0);
  endtask

  task automatic testThresholds();
    doReset();
    busWrite(1'b1, ctrlWord(0, 0, 1, 1, 0, 3, 2));
    for (int i = 0; i < 3; i++) busWrite(1'b0, 32'(i));
    chk("R6 tx irq at 3", {30'd0, txIrq, txDmaReq}, 3);
    busWrite(1'b0, 32'h3);
    chk("R6 tx irq at 4", {30'd0, txIrq, txDmaReq}, 3);
    busWrite(1'b0, 32'h4);
    chk("R6 tx irq at 5", {30'd0, txIrq, txDmaReq}, 0);
    shiftPush(1); shiftPush(2);
    chk("R7 rx irq at 2", {30'd0, rxIrq, rxDmaReq}, 0);
    shiftPush(3);
    chk("R7 rx irq at 3", {30'd0, rxIrq, rxDmaReq}, 3);
    busWrite(1'b1, ctrlWord(0, 0, 0, 0, 0, 3, 2));
    txPop = 1'b1; tick(); tick(); txPop = 1'b0;
    chk("R8 tx gated", {30'd0, txIrq, txDmaReq}, 2);
    chk("R8 rx gated", {30'd0, rxIrq, rxDmaReq}, 2);
  endtask

  task automatic testMode();
    logic [31:0] d;
    doReset();
    busWrite(1'b1, ctrlWord(1, 0, 0, 0, 0, 0, 0));
    busWrite(1'b0, 32'h1122_3344);
    busWrite(1'b1, ctrlWord(1, 2, 0, 0, 1, 0, 0));
    busWrite(1'b0, 32'h5566_7788);
    chk("R11 rx got bus write", 32'(rxCount), 1);
    chk("R11 tx untouched", 32'(txCount), 1);
    shiftPush(32'h9999_9999);
    chk("R11 rxPush ignored", 32'(rxCount), 1);
    shiftPop(d);
    chk("R11 txPop ignored", 32'(txCount), 1);
    busRead(1'b0, d);
    chk("R11 read tx raw", d, expSwap(32'h1122_3344, 1));
    chk("R11 tx popped", 32'(txCount), 0);
    busWrite(1'b1, 32'h0);
    busRead(1'b0, d);
    chk("R11 rx stored raw", d, 32'h5566_7788);
  endtask

  task automatic testSimul();
    doReset();
    busWrite(1'b0, 32'hA); busWrite(1'b0, 32'hB);
    busSel = 1'b1; busWr = 1'b1; busAddr = 1'b0; busWdata = 32'hC; txPop = 1'b1;
    tick();
    busSel = 1'b0; busWr = 1'b0; txPop = 1'b0;
    chk("R12 tx count same", 32'(txCount), 2);
    chk("R12 tx head advanced", txPopData, 32'hB);
    shiftPush(32'h1);
    busSel = 1'b1; busWr = 1'b0; busAddr = 1'b0; rxPush = 1'b1; rxPushData = 32'h2;
    tick();
    busSel = 1'b0; rxPush = 1'b0;
    chk("R12 rx count same", 32'(rxCount), 1);
    chk("R12 no errors", {28'd0, txOverrun, txUnderrun, rxOverrun, rxUnderrun}, 0);
  endtask

  initial begin
    #(200000 * 5);
    if (!finished) begin
      fails++;
      checks++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end

  initial begin
    testReset();
    testCtrlReg();
    testTxSwap();
    testRxSwap();
    testOrderAndFull();
    testRxLimits();
    testThresholds();
    testMode();
    testSimul();
    finished = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

endmodule